// File: doc/BRIEF.md
# I2C Master Condition Sequencer

This block holds the 8-bit control register of an I2C master and decides when that master issues a start, a repeated start or a stop condition on the bus. A CPU writes and reads the register through a simple write port and a read-back bus. A bit-level bus engine sits behind the block. The engine reports when a byte is ready to send, when it is busy shifting a byte or its acknowledge, when a byte and its acknowledge have finished, when a byte has been received, and when a slave transaction addressed to this device is in progress. In return the engine receives one-cycle strobes asking it to generate a start or a stop. It answers each strobe with a done pulse once the condition is on the bus.

The start and stop request bits clear themselves. The CPU can only set them, and only while the controller is enabled. A start request stays pending until a byte is ready. A stop request waits for a byte boundary. When both are pending, the stop goes out first. If a slave transaction is in progress, a pending start is cancelled and reported as lost arbitration, and a pending stop is dropped without being issued.

Top module: `bus_cond_sequencer`

## Requirements
- R1: After reset the register reads 0x00, and gen_start_o, gen_stop_o, flush_o and arb_lost_o are all 0.
- R2: The register bit positions are: enable bit 7, start request bit 6, stop request bit 5, timer interrupt bit 4, transmit interrupt bit 3, NAK bit 2, flush bit 1, filter enable bit 0. The enable, timer, transmit-interrupt and filter bits are plain read/write.
- R3: The start, stop and NAK bits are set by writing 1 only if enable already reads 1 before the write. Writing 0 to any of these bits leaves it unchanged.
- R4: A write that leaves enable at 0 clears the start, stop and NAK bits in the same cycle and returns the sequencer to idle.
- R5: gen_start_o pulses for one cycle only while start is pending, no stop is pending, data_avail_i is 1, xfer_busy_i is 0 and slave_busy_i is 0. Without data the request stays pending. The start bit clears on the cond_done_i that follows the pulse.
- R6: A start requested while xfer_busy_i is 1 is held back, and the repeated start is issued once xfer_busy_i falls.
- R7: gen_stop_o pulses only when stop is pending, xfer_busy_i is 0, and a byte_ack_done_i or byte_rx_done_i has been seen since the last issued condition. The stop bit clears on the cond_done_i that follows the pulse.
- R8: When start and stop are both pending, the stop is issued first and the start follows after the stop's cond_done_i.
- R9: A pending start while slave_busy_i is 1 is cleared without a strobe and sets arb_lost_o. arb_lost_o holds until an arb_clr_i pulse.
- R10: A pending stop while slave_busy_i is 1 is cleared without gen_stop_o, and arb_lost_o is left unchanged.
- R11: Writing 1 to bit 1 gives a one-cycle flush_o pulse in the cycle after the write, and bit 1 always reads 0.
- R12: gen_start_o and gen_stop_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read-back |
| arb_clr_i | input | 1 | Write-one-to-clear strobe for arbitration lost |
| data_avail_i | input | 1 | Engine has a byte ready to transmit |
| xfer_busy_i | input | 1 | Engine is shifting a byte or its acknowledge |
| byte_ack_done_i | input | 1 | Pulse: transmitted byte and acknowledge finished |
| byte_rx_done_i | input | 1 | Pulse: byte received |
| slave_busy_i | input | 1 | Slave transaction to this device in progress |
| cond_done_i | input | 1 | Pulse: requested condition has been generated |
| gen_start_o | output | 1 | One-cycle request to generate start |
| gen_stop_o | output | 1 | One-cycle request to generate stop |
| flush_o | output | 1 | One-cycle data flush pulse |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench holds a start request with no data ready and with a byte still shifting. A design that does not wait for data, or that does not wait for the byte to finish, would strobe too early. It also raises start and stop together, and a design with the wrong priority would issue the start before the stop. Stop is requested before any byte has completed, to catch a design that closes the bus at once. Writes of 0 and writes made while disabled are used to show that the request bits cannot be cleared or set from software. A slave transaction is used to show that start turns into lost arbitration while stop disappears silently. A design that mixes these two up would either emit strobes or leave the flag in the wrong state.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;
  localparam int REG_W   = 8;
  localparam int B_EN    = 7;
  localparam int B_STA   = 6;
  localparam int B_STO   = 5;
  localparam int B_TMR   = 4;
  localparam int B_TXI   = 3;
  localparam int B_NAK   = 2;
  localparam int B_FLUSH = 1;
  localparam int B_FILT  = 0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_STOP} sq_state_e;
endpackage

// File: rtl/cond_cfg_reg.sv
module cond_cfg_reg
  import bus_cond_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_sta_i,
  input  logic         clr_sto_i,
  output logic [W-1:0] reg_o,
  output logic         flush_o
);
  logic en_q, sta_q, sto_q, nak_q, tmr_q, txi_q, filt_q;
  logic en_d, sta_set, sto_set, nak_set;

  assign en_d    = wr_en_i ? wr_data_i[B_EN] : en_q;
  // sticky bits settable only when already enabled
  assign sta_set = wr_en_i & wr_data_i[B_STA] & en_q;
  assign sto_set = wr_en_i & wr_data_i[B_STO] & en_q;
  assign nak_set = wr_en_i & wr_data_i[B_NAK] & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sta_q   <= 1'b0;
      sto_q   <= 1'b0;
      nak_q   <= 1'b0;
      tmr_q   <= 1'b0;
      txi_q   <= 1'b0;
      filt_q  <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      en_q    <= en_d;
      sta_q   <= en_d & ((sta_q & ~clr_sta_i) | sta_set);
      sto_q   <= en_d & ((sto_q & ~clr_sto_i) | sto_set);
      nak_q   <= en_d & (nak_q | nak_set);
      flush_o <= wr_en_i & wr_data_i[B_FLUSH];
      if (wr_en_i) begin
        tmr_q  <= wr_data_i[B_TMR];
        txi_q  <= wr_data_i[B_TXI];
        filt_q <= wr_data_i[B_FILT];
      end
    end
  end

  always_comb begin
    reg_o          = '0;
    reg_o[B_EN]    = en_q;
    reg_o[B_STA]   = sta_q;
    reg_o[B_STO]   = sto_q;
    reg_o[B_TMR]   = tmr_q;
    reg_o[B_TXI]   = txi_q;
    reg_o[B_NAK]   = nak_q;
    reg_o[B_FILT]  = filt_q;
  end
endmodule

// File: rtl/cond_seq_fsm.sv
module cond_seq_fsm
  import bus_cond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sta_i,
  input  logic sto_i,
  input  logic data_avail_i,
  input  logic xfer_busy_i,
  input  logic byte_ack_done_i,
  input  logic byte_rx_done_i,
  input  logic slave_busy_i,
  input  logic cond_done_i,
  input  logic arb_clr_i,
  output logic gen_start_o,
  output logic gen_stop_o,
  output logic clr_sta_o,
  output logic clr_sto_o,
  output logic arb_lost_o
);
  sq_state_e state_q, state_d;
  logic byte_seen_q;
  logic idle, cancel_sta, cancel_sto;

  assign idle       = (state_q == SQ_IDLE) & en_i;
  assign cancel_sta = idle & sta_i & slave_busy_i;
  assign cancel_sto = idle & sto_i & slave_busy_i;

  assign gen_stop_o  = idle & sto_i & ~slave_busy_i & ~xfer_busy_i & byte_seen_q;
  // stop takes precedence over start
  assign gen_start_o = idle & sta_i & ~sto_i & ~slave_busy_i & ~xfer_busy_i & data_avail_i;

  assign clr_sta_o = cancel_sta | ((state_q == SQ_START) & cond_done_i);
  assign clr_sto_o = cancel_sto | ((state_q == SQ_STOP) & cond_done_i);

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = SQ_IDLE;
    else begin
      unique case (state_q)
        SQ_IDLE:  if (gen_stop_o) state_d = SQ_STOP;
                  else if (gen_start_o) state_d = SQ_START;
        SQ_START: if (cond_done_i) state_d = SQ_IDLE;
        SQ_STOP:  if (cond_done_i) state_d = SQ_IDLE;
        default:  state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_IDLE;
      byte_seen_q <= 1'b0;
      arb_lost_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!en_i || gen_start_o || gen_stop_o) byte_seen_q <= 1'b0;
      else if (byte_ack_done_i || byte_rx_done_i) byte_seen_q <= 1'b1;
      if (cancel_sta) arb_lost_o <= 1'b1;
      else if (arb_clr_i) arb_lost_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_cond_sequencer.sv
module bus_cond_sequencer
  import bus_cond_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             arb_clr_i,
  input  logic             data_avail_i,
  input  logic             xfer_busy_i,
  input  logic             byte_ack_done_i,
  input  logic             byte_rx_done_i,
  input  logic             slave_busy_i,
  input  logic             cond_done_i,
  output logic             gen_start_o,
  output logic             gen_stop_o,
  output logic             flush_o,
  output logic             arb_lost_o
);
  logic clr_sta, clr_sto;

  cond_cfg_reg #(.W(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_sta_i (clr_sta),
    .clr_sto_i (clr_sto),
    .reg_o     (rd_data_o),
    .flush_o   (flush_o)
  );

  cond_seq_fsm u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (rd_data_o[B_EN]),
    .sta_i           (rd_data_o[B_STA]),
    .sto_i           (rd_data_o[B_STO]),
    .data_avail_i    (data_avail_i),
    .xfer_busy_i     (xfer_busy_i),
    .byte_ack_done_i (byte_ack_done_i),
    .byte_rx_done_i  (byte_rx_done_i),
    .slave_busy_i    (slave_busy_i),
    .cond_done_i     (cond_done_i),
    .arb_clr_i       (arb_clr_i),
    .gen_start_o     (gen_start_o),
    .gen_stop_o      (gen_stop_o),
    .clr_sta_o       (clr_sta),
    .clr_sto_o       (clr_sto),
    .arb_lost_o      (arb_lost_o)
  );
endmodule

// File: rtl/bus_cond_sequencer_chk.sv
module bus_cond_sequencer_chk
  import bus_cond_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             arb_clr_i,
  input logic             data_avail_i,
  input logic             xfer_busy_i,
  input logic             slave_busy_i,
  input logic             gen_start_o,
  input logic             gen_stop_o,
  input logic             flush_o,
  input logic             arb_lost_o
);
  a_r12_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gen_start_o && gen_stop_o));

  a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_start_o |=> !gen_start_o);

  a_r5_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_start_o |-> (rd_data_o[B_STA] && !rd_data_o[B_STO] && data_avail_i && !xfer_busy_i && !slave_busy_i));

  a_r7_stop_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_stop_o |-> (rd_data_o[B_STO] && !xfer_busy_i && !slave_busy_i));

  a_r4_disabled_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[B_EN] |-> (!rd_data_o[B_STA] && !rd_data_o[B_STO] && !rd_data_o[B_NAK]));

  a_r3_start_set_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_STA]) |-> $past(wr_en_i && wr_data_i[B_STA] && rd_data_o[B_EN]));

  a_r9_arb_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> $past(slave_busy_i && rd_data_o[B_STA]));

  a_r9_arb_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && !arb_clr_i) |=> arb_lost_o);

  a_r11_flush_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_en_i && wr_data_i[B_FLUSH]));
endmodule

bind bus_cond_sequencer bus_cond_sequencer_chk u_chk (.*);

// File: tb/sim_bus_cond_sequencer.sv
module sim_bus_cond_sequencer;
  localparam time CLK_P = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       arb_clr_i = 1'b0;
  logic       data_avail_i = 1'b0;
  logic       xfer_busy_i = 1'b0;
  logic       byte_ack_done_i = 1'b0;
  logic       byte_rx_done_i = 1'b0;
  logic       slave_busy_i = 1'b0;
  logic       cond_done_i = 1'b0;
  logic       gen_start_o, gen_stop_o, flush_o, arb_lost_o;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  bus_cond_sequencer u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic done_pulse();
    @(negedge clk_i); cond_done_i = 1'b1;
    @(negedge clk_i); cond_done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reg", rd_data_o, 8'h00);
    chk("R1 outs", {4'h0, gen_start_o, gen_stop_o, flush_o, arb_lost_o}, 8'h00);
  endtask

  task automatic t_plain_bits();
    wr(8'h99);
    chk("R2 plain bits", rd_data_o, 8'h99);
    wr(8'h00);
    chk("R2 cleared", rd_data_o, 8'h00);
  endtask

  task automatic t_write_one();
    wr(8'h64);
    chk("R3 set while disabled", rd_data_o, 8'h00);
    wr(8'h80);
    wr(8'h84);
    chk("R3 nak set", rd_data_o, 8'h84);
    wr(8'h80);
    chk("R3 nak not cleared by 0", rd_data_o, 8'h84);
    wr(8'h00);
    chk("R4 disable clears nak", rd_data_o, 8'h00);
  endtask

  task automatic t_start_wait_data();
    data_avail_i = 1'b0;
    wr(8'h80);
    wr(8'hC0);
    chk("R5 pending no data", {7'h0, gen_start_o}, 8'h00);
    idle(3);
    chk("R5 still pending", {rd_data_o[6], gen_start_o}, 8'h02);
    data_avail_i = 1'b1; #1;
    chk("R5 start strobe", {7'h0, gen_start_o}, 8'h01);
    @(negedge clk_i);
    chk("R5 one-cycle strobe", {rd_data_o[6], gen_start_o}, 8'h02);
    cond_done_i = 1'b1;
    @(negedge clk_i); cond_done_i = 1'b0;
    chk("R5 start self-clears", {rd_data_o[6], gen_start_o}, 8'h00);
  endtask

  task automatic t_stop_waits_byte();
    wr(8'hA0);
    idle(2);
    chk("R7 no stop before byte", {7'h0, gen_stop_o}, 8'h00);
    @(negedge clk_i); byte_rx_done_i = 1'b1;
    @(negedge clk_i); byte_rx_done_i = 1'b0;
    chk("R7 stop after rx byte", {7'h0, gen_stop_o}, 8'h01);
    done_pulse();
    chk("R7 stop self-clears", {rd_data_o[5], gen_stop_o}, 8'h00);
  endtask

  task automatic t_restart_busy();
    data_avail_i = 1'b1; xfer_busy_i = 1'b1;
    wr(8'hC0);
    idle(2);
    chk("R6 held during shift", {7'h0, gen_start_o}, 8'h00);
    xfer_busy_i = 1'b0; #1;
    chk("R6 restart after byte", {7'h0, gen_start_o}, 8'h01);
    done_pulse();
    chk("R6 cleared", {7'h0, rd_data_o[6]}, 8'h00);
  endtask

  task automatic t_stop_first();
    @(negedge clk_i); byte_ack_done_i = 1'b1;
    @(negedge clk_i); byte_ack_done_i = 1'b0;
    wr(8'hE0);
    chk("R8 stop first", {gen_start_o, gen_stop_o}, 8'h01);
    done_pulse();
    chk("R8 start follows", {gen_start_o, gen_stop_o, rd_data_o[6:5]}, 8'h0A);
    done_pulse();
    chk("R8 both cleared", {6'h0, rd_data_o[6:5]}, 8'h00);
  endtask

  task automatic t_slave_start();
    slave_busy_i = 1'b1;
    wr(8'hC0);
    chk("R9 no strobe", {gen_start_o, arb_lost_o}, 8'h00);
    @(negedge clk_i);
    chk("R9 cancel + arb", {rd_data_o[6], arb_lost_o}, 8'h01);
    idle(2);
    chk("R9 arb sticky", {7'h0, arb_lost_o}, 8'h01);
    arb_clr_i = 1'b1;
    @(negedge clk_i); arb_clr_i = 1'b0;
    chk("R9 arb cleared", {7'h0, arb_lost_o}, 8'h00);
    slave_busy_i = 1'b0;
  endtask

  task automatic t_slave_stop();
    @(negedge clk_i); byte_ack_done_i = 1'b1;
    @(negedge clk_i); byte_ack_done_i = 1'b0;
    slave_busy_i = 1'b1;
    wr(8'hA0);
    chk("R10 no stop strobe", {7'h0, gen_stop_o}, 8'h00);
    @(negedge clk_i);
    chk("R10 stop dropped", {rd_data_o[5], gen_stop_o, arb_lost_o}, 8'h00);
    slave_busy_i = 1'b0; #1;
    chk("R10 stays dropped", {7'h0, gen_stop_o}, 8'h00);
  endtask

  task automatic t_disable_clears();
    data_avail_i = 1'b0;
    wr(8'hC4);
    chk("R3 start+nak set", rd_data_o, 8'hC4);
    wr(8'h00);
    chk("R4 disable clears", rd_data_o, 8'h00);
    wr(8'h80);
    data_avail_i = 1'b1; #1;
    chk("R4 no stale start", {7'h0, gen_start_o}, 8'h00);
  endtask

  task automatic t_flush();
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = 8'h82;
    @(negedge clk_i); wr_en_i = 1'b0; wr_data_i = '0;
    chk("R11 flush pulse", {7'h0, flush_o}, 8'h01);
    chk("R11 reads 0", {7'h0, rd_data_o[1]}, 8'h00);
    @(negedge clk_i);
    chk("R11 flush one cycle", {7'h0, flush_o}, 8'h00);
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 3);
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_plain_bits();
    t_write_one();
    t_start_wait_data();
    t_stop_waits_byte();
    t_restart_busy();
    t_stop_first();
    t_slave_start();
    t_slave_stop();
    t_disable_clears();
    t_flush();
    finish_run();
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule